// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a per-processor countdown timer that raises a local interrupt request. It runs off the bus clock. A prescaler takes that clock and produces a decrement tick every n-th cycle, where n is chosen by a divide setting. Software programs three things through a simple register write port:

- the divide setting;
- the initial count;
- a vector-table entry, which holds an 8-bit vector, a mask bit and a mode bit that selects one-shot or periodic operation.

The live counter value is always available on an output.

When the counter reaches zero, the block either stops there (one-shot) or reloads the initial count and continues (periodic). Each zero crossing that happens while the entry is unmasked sets a pending request flag. The request is presented with the vector from the entry, using fixed delivery. The flag stays set until an end-of-interrupt strobe arrives. Zero crossings that occur while the flag is already set are merged into the one outstanding request.

Top module: `countdown_irq_timer`

## Requirements
- R1: After reset, the count output is 0 and no request is pending. The entry reads back with its mask set, one-shot mode, and vector 0.
- R2: A write asserts `wr_en` for one clock. `wr_sel` selects the target: 0 is the divide setting (`wr_data[2:0]`), 1 is the initial count (`wr_data[31:0]`), and 2 is the entry. In the entry, bits 7:0 hold the vector, bit 16 the mask, and bit 17 the mode (1 = periodic).
- R3: A divide code c gives a divisor of 2^c, so codes 0 to 7 select 1, 2, 4, ..., 128. The counter decrements once every 2^c clocks. The first decrement lands 2^c clock edges after the edge that loaded the initial count.
- R4: Writing a nonzero initial count loads the counter with that value and starts counting. Writing zero clears the counter and stops it.
- R5: One-shot mode: the count reaches 0 exactly N*2^c edges after the load, and one request is raised at that edge. The counter then stays at 0 and raises no further request.
- R6: Periodic mode: on the edge where the count would reach zero, the counter instead reloads the initial count and raises a request. Requests therefore recur every N*2^c edges.
- R7: While the mask bit is set, the counter still counts and reloads, but no request becomes pending.
- R8: A pending request stays set until an `eoi` strobe clears it. A zero crossing while the request is pending is merged into it. A crossing on the same edge as `eoi` leaves the request pending.
- R9: Writing the divide setting restarts the prescaler phase. No decrement happens on the edge of that write, and the next decrement comes a full 2^c edges later. A write of the initial count restarts the phase in the same way.
- R10: The request vector output and the entry fields always reflect the last write to the entry.
- R11: The count output shows the live counter. It only drops by exactly one per tick. It only rises on an initial-count write or a periodic reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 divide, 1 initial count, 2 entry |
| wr_data | input | 32 | Write data |
| eoi | input | 1 | End-of-interrupt strobe, clears the pending request |
| cur_count | output | 32 | Live counter value |
| irq_pending | output | 1 | Interrupt request pending |
| irq_vector | output | 8 | Vector delivered with the request (fixed mode) |
| cfg_mask | output | 1 | Mask bit of the entry |
| cfg_periodic | output | 1 | Mode bit of the entry (1 = periodic) |

## Verification
Each result is due at a fixed clock edge:

- A register write takes effect on the edge where `wr_en` is sampled.
- The count after a load shows N - floor(m/2^c) after m further edges.
- The pending flag rises on the same edge on which the count reaches zero or reloads.
- The pending flag falls on the edge where `eoi` is sampled.

The bench drives inputs and samples outputs at the falling clock edge. Every wait is a counted number of edges from the write, so the expected value is computed from m and 2^c alone. The edge cases are placed on exact edges: a terminal count reached on exactly the N*2^c-th edge, one edge short of a prescaler wrap, and a zero crossing coinciding with `eoi`.

// File: rtl/cdt_pkg.sv
// Package: shared constants and register select codes for the countdown timer.
// Assumes a 32-bit write data path; entry field positions are fixed because
// software decodes them.
package cdt_pkg;
    localparam int DATA_W      = 32;
    localparam int SEL_W       = 2;
    localparam int ENTRY_MASK  = 16;
    localparam int ENTRY_MODE  = 17;

    typedef enum logic [SEL_W-1:0] {
        SEL_DIV   = 2'd0,
        SEL_INIT  = 2'd1,
        SEL_ENTRY = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/cdt_prescaler.sv
// Prescaler: emits one tick every 2**div_code clocks while the timer runs.
// Assumes restart is a one-clock strobe; a restart zeroes the phase and
// suppresses the tick on that edge.
module cdt_prescaler #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic              restart,
    input  logic [CODE_W-1:0] div_code,
    output logic              tick
);
    localparam int PS_W = (1 << CODE_W) - 1;

    logic [PS_W-1:0] phase;
    logic [PS_W-1:0] terminal;

    // Terminal phase value for the selected divisor.
    always_comb begin
        terminal = PS_W'((1 << div_code) - 1);
    end

    // A tick fires when the phase hits its terminal value.
    always_comb begin
        tick = running && !restart && (phase == terminal);
    end

    // Phase counter: cleared on restart, wraps on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart || !running || tick) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/cdt_counter.sv
// Counter: loads on an initial-count write and decrements on each prescaler
// tick. On reaching zero it stops (one-shot) or reloads (periodic), and
// raises a one-cycle fire pulse. Assumes load and tick are never both set
// (the prescaler suppresses the tick on a load).
module cdt_counter #(
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [COUNT_W-1:0] load_val,
    input  logic               tick,
    input  logic               periodic,
    output logic [COUNT_W-1:0] count,
    output logic               running,
    output logic               fire
);
    localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

    logic [COUNT_W-1:0] reload;

    // A zero crossing happens on the tick that leaves the count at one.
    always_comb begin
        fire = tick && (count == ONE);
    end

    // Count, reload value and run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            reload  <= '0;
            running <= 1'b0;
        end else if (load) begin
            count   <= load_val;
            reload  <= load_val;
            running <= (load_val != '0);
        end else if (fire) begin
            if (periodic) begin
                count <= reload;
            end else begin
                count   <= '0;
                running <= 1'b0;
            end
        end else if (tick) begin
            count <= count - ONE;
        end
    end
endmodule

// File: rtl/cdt_irq.sv
// Request latch: sets the pending flag on an unmasked fire and clears it on
// end-of-interrupt. A fire on the same edge as eoi wins. Assumes fire is a
// one-cycle pulse.
module cdt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic masked,
    input  logic eoi,
    output logic pending
);
    // Pending flag with merge and set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (fire && !masked) begin
            pending <= 1'b1;
        end else if (eoi) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/countdown_irq_timer.sv
// Top: holds the divide setting and the vector-table entry, and wires the
// prescaler, counter and request latch. Assumes single-cycle write strobes
// on a bus clock shared with software.
module countdown_irq_timer #(
    parameter int COUNT_W = 32,
    parameter int VEC_W   = 8,
    parameter int CODE_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [cdt_pkg::SEL_W-1:0] wr_sel,
    input  logic [31:0]               wr_data,
    input  logic                      eoi,
    output logic [COUNT_W-1:0]        cur_count,
    output logic                      irq_pending,
    output logic [VEC_W-1:0]          irq_vector,
    output logic                      cfg_mask,
    output logic                      cfg_periodic
);
    import cdt_pkg::*;

    logic              div_wr, init_wr, entry_wr;
    logic [CODE_W-1:0] div_code;
    logic [VEC_W-1:0]  vec_q;
    logic              mask_q, mode_q;
    logic              tick, running, fire;

    // Decode the register select.
    always_comb begin
        div_wr   = wr_en && (wr_sel == SEL_DIV);
        init_wr  = wr_en && (wr_sel == SEL_INIT);
        entry_wr = wr_en && (wr_sel == SEL_ENTRY);
    end

    // Divide setting register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_code <= '0;
        end else if (div_wr) begin
            div_code <= wr_data[CODE_W-1:0];
        end
    end

    // Vector-table entry: the reset value is masked, one-shot, vector 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q  <= '0;
            mask_q <= 1'b1;
            mode_q <= 1'b0;
        end else if (entry_wr) begin
            vec_q  <= wr_data[VEC_W-1:0];
            mask_q <= wr_data[ENTRY_MASK];
            mode_q <= wr_data[ENTRY_MODE];
        end
    end

    cdt_prescaler #(.CODE_W(CODE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running),
        .restart  (div_wr || init_wr),
        .div_code (div_code),
        .tick     (tick)
    );

    cdt_counter #(.COUNT_W(COUNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (init_wr),
        .load_val (wr_data[COUNT_W-1:0]),
        .tick     (tick),
        .periodic (mode_q),
        .count    (cur_count),
        .running  (running),
        .fire     (fire)
    );

    cdt_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .masked  (mask_q),
        .eoi     (eoi),
        .pending (irq_pending)
    );

    // Expose the entry fields; delivery is always in fixed mode.
    always_comb begin
        irq_vector   = vec_q;
        cfg_mask     = mask_q;
        cfg_periodic = mode_q;
    end
endmodule

// File: rtl/cdt_checker.sv
// Checker: temporal properties of the countdown timer, observed at its ports.
module cdt_checker #(
    parameter int COUNT_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [1:0]         wr_sel,
    input logic               eoi,
    input logic [COUNT_W-1:0] cur_count,
    input logic               irq_pending,
    input logic               cfg_mask,
    input logic               cfg_periodic
);
    // R7: a request only becomes pending while the entry was unmasked.
    p_masked_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pending) |-> !$past(cfg_mask));

    // R8: a pending request only clears after an eoi strobe.
    p_clear_needs_eoi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_pending) |-> $past(eoi));

    // R5: a stopped (zero) counter stays at zero until a new initial count.
    p_zero_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_count == '0 && !(wr_en && wr_sel == 2'd1)) |=> cur_count == '0);

    // R11: the count rises only on a load or a periodic reload.
    p_rise_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_count > $past(cur_count)) |->
            ($past(wr_en && wr_sel == 2'd1) ||
             ($past(cur_count) == COUNT_W'(1) && $past(cfg_periodic))));

    // R11: the count drops by one per tick, except on a load.
    p_step_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_count < $past(cur_count)) |->
            ($past(wr_en && wr_sel == 2'd1) ||
             cur_count == $past(cur_count) - COUNT_W'(1) ||
             (cur_count == '0 && $past(cur_count) == COUNT_W'(1))));
endmodule

bind countdown_irq_timer cdt_checker #(.COUNT_W(COUNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .eoi          (eoi),
    .cur_count    (cur_count),
    .irq_pending  (irq_pending),
    .cfg_mask     (cfg_mask),
    .cfg_periodic (cfg_periodic)
);

// File: tb/countdown_irq_timer_bench.sv
// Bench: a table of programmed scenarios followed by directed corner tests.
module countdown_irq_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        eoi = 1'b0;
    logic [31:0] cur_count;
    logic        irq_pending;
    logic [7:0]  irq_vector;
    logic        cfg_mask;
    logic        cfg_periodic;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    countdown_irq_timer u_countdown_irq_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .eoi(eoi), .cur_count(cur_count),
        .irq_pending(irq_pending), .irq_vector(irq_vector),
        .cfg_mask(cfg_mask), .cfg_periodic(cfg_periodic)
    );

    // Scenario table: div code, initial count, periodic, edges waited,
    // expected count, expected pending.
    localparam int NROW = 8;
    localparam int T_CODE [NROW] = '{0, 1, 3, 0, 0, 7, 7, 2};
    localparam int T_INIT [NROW] = '{10, 10, 5, 3, 4, 2, 2, 3};
    localparam int T_PER  [NROW] = '{0, 0, 0, 0, 1, 1, 1, 1};
    localparam int T_WAIT [NROW] = '{4, 7, 40, 100, 6, 127, 128, 11};
    localparam int T_CNT  [NROW] = '{6, 7, 0, 0, 2, 2, 1, 1};
    localparam int T_PEND [NROW] = '{0, 0, 1, 1, 1, 0, 0, 0};

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_eoi();
        eoi = 1'b1;
        @(negedge clk);
        eoi = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic entry(input bit per, input bit msk, input logic [7:0] vec);
        wr(2'd2, {14'd0, per, msk, 8'd0, vec});
    endtask

    task automatic stop_and_clear();
        wr(2'd1, 32'd0);
        pulse_eoi();
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        check("R1 count", cur_count, 0);
        check("R1 pending", irq_pending, 0);
        check("R1 mask", cfg_mask, 1);
        check("R1 mode", cfg_periodic, 0);
        check("R1 vector", irq_vector, 0);

        // R3 R4 R5 R6: table of scenarios.
        for (int i = 0; i < NROW; i++) begin
            entry(T_PER[i][0], 1'b0, 8'h40);
            wr(2'd0, T_CODE[i]);
            wr(2'd1, T_INIT[i]);
            wait_edges(T_WAIT[i]);
            check($sformatf("R3/R5/R6 row%0d count", i), cur_count, T_CNT[i]);
            check($sformatf("R5/R6 row%0d pending", i), irq_pending, T_PEND[i]);
            stop_and_clear();
        end

        // R10 R2: entry fields and vector.
        entry(1'b1, 1'b0, 8'h5A);
        check("R10 vector", irq_vector, 8'h5A);
        check("R2 mode bit17", cfg_periodic, 1);
        check("R2 mask bit16", cfg_mask, 0);

        // R7: masked one-shot still counts to zero without a request.
        entry(1'b0, 1'b1, 8'h21);
        wr(2'd0, 0);
        wr(2'd1, 3);
        wait_edges(10);
        check("R7 masked count", cur_count, 0);
        check("R7 masked pending", irq_pending, 0);
        stop_and_clear();

        // R7: masked periodic still reloads.
        entry(1'b1, 1'b1, 8'h21);
        wr(2'd1, 3);
        wait_edges(4);
        check("R7 masked reload", cur_count, 2);
        check("R7 masked periodic pending", irq_pending, 0);
        stop_and_clear();

        // R5 R8: one-shot request cleared by eoi, no second request.
        entry(1'b0, 1'b0, 8'h30);
        wr(2'd1, 2);
        wait_edges(2);
        check("R5 fired", irq_pending, 1);
        pulse_eoi();
        check("R8 eoi clears", irq_pending, 0);
        wait_edges(20);
        check("R5 stays zero", cur_count, 0);
        check("R5 single request", irq_pending, 0);

        // R8: merge, and a fire on the eoi edge keeps the request pending.
        entry(1'b1, 1'b0, 8'h30);
        wr(2'd1, 2);
        wait_edges(5);
        check("R8 merged pending", irq_pending, 1);
        check("R6 count mid-period", cur_count, 1);
        pulse_eoi();
        check("R8 fire beats eoi", irq_pending, 1);
        pulse_eoi();
        check("R8 eoi clears after merge", irq_pending, 0);
        stop_and_clear();

        // R4: writing zero stops the counter.
        entry(1'b0, 1'b0, 8'h30);
        wr(2'd1, 10);
        wait_edges(3);
        check("R4 counting", cur_count, 7);
        wr(2'd1, 0);
        check("R4 zero clears", cur_count, 0);
        wait_edges(5);
        check("R4 stopped", cur_count, 0);
        check("R4 no request", irq_pending, 0);

        // R9: a divide write restarts the prescaler phase.
        wr(2'd0, 1);
        wr(2'd1, 10);
        wait_edges(3);
        check("R9 before restart", cur_count, 9);
        wr(2'd0, 1);
        check("R9 no tick on write", cur_count, 9);
        wait_edges(1);
        check("R9 phase held", cur_count, 9);
        wait_edges(1);
        check("R9 tick after full period", cur_count, 8);
        stop_and_clear();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule